// File: doc/BRIEF.md
# Wavefront Instruction Fetch Controller

This block decides which of a fixed set of wavefront slots gets its instruction buffer refilled next, and turns that choice into one memory read. Every cycle it checks each slot's reported state: whether it is running, how full its buffer is, whether the buffer holds a branch, and whether a fetch is already in flight. Slots that qualify join an in-order ready list. The oldest entry on the list is issued when the request port is free.

For the chosen slot the block forms a byte address from the slot's base pointer, program counter and current buffer fill, using 8-byte instruction words. It requests the bytes from that address up to the end of the cache line, so a request never spans two lines. Returns come back tagged with the slot number. Their words go straight to the buffer-write interface, unless the slot was flushed while its fetch was in flight. In that case the return is thrown away.

Top module: `wf_fetch_ctrl`

## Requirements
- R1: A slot qualifies for fetch only while `slot_running` is 1, its `slot_occ` is 4 or less, `slot_has_branch` is 0 and it has no fetch outstanding. A slot that fails any of these produces no request.
- R2: A qualifying slot enters the ready list once. It does not enter again while it is still listed, so each qualification yields exactly one request.
- R3: Listed slots are issued oldest first. Slots that qualify in the same cycle are listed in ascending slot number.
- R4: If the ready list is empty and the port is free, a slot that qualifies in cycle t is issued in that same cycle. `req_valid` is then high in cycle t+1.
- R5: `req_addr` equals base + (PC + occupancy) × 8, all taken at the time the slot is issued.
- R6: `req_len` is 64 minus (`req_addr` mod 64), so it is 64 for an aligned address and never crosses into the next line (default line size 64 bytes).
- R7: While `req_valid` is 1 and `req_ready` is 0, the address, length and slot on the port hold steady and no other slot is issued.
- R8: A pulse on `drop_set[i]` marks slot i. The next return for slot i produces no buffer write and clears the mark, so later returns are written normally. The slot's occupancy must be 0 when such a return arrives.
- R9: A return for an unmarked slot drives `ibuf_wr_valid` in the same cycle, with `ibuf_wr_count` = `rsp_len`/8 and the words passed through lowest address in bits [63:0]. Every return ends that slot's outstanding fetch.
- R10: During and right after reset, `req_valid` and `ibuf_wr_valid` are 0 and no slot is listed, outstanding or marked.
- R11: A slot has at most one fetch outstanding. It is not issued again until its return has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slot_running | input | N | Slot i is running |
| slot_has_branch | input | N | Slot i's buffer holds a branch |
| slot_occ | input | N*OCC_W | Instruction-buffer fill per slot, in words |
| slot_pc | input | N*PC_W | Program counter per slot, in words |
| slot_base | input | N*ADDR_W | Byte base pointer per slot |
| drop_set | input | N | Mark slot i's in-flight fetch as stale |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Fetch byte address |
| req_len | output | LEN_W | Fetch length in bytes |
| req_slot | output | SLOT_W | Requesting slot |
| rsp_valid | input | 1 | Fetch return valid |
| rsp_slot | input | SLOT_W | Slot the return belongs to |
| rsp_len | input | LEN_W | Returned bytes |
| rsp_data | input | LINE_BYTES*8 | Returned words, lowest address at bit 0 |
| ibuf_wr_valid | output | 1 | Write returned words to a buffer |
| ibuf_wr_slot | output | SLOT_W | Target slot buffer |
| ibuf_wr_count | output | WCNT_W | Number of words to write |
| ibuf_wr_data | output | LINE_BYTES*8 | Words to write, in address order |

## Verification
Address and length generation is checked against a table of base, PC and occupancy triples. The table covers aligned addresses, one word past a line start, the last word of a line and addresses in mid-line, which separates a correct offset calculation from one that ignores the offset or clamps it wrongly. Eligibility is tested one condition at a time: over-full buffer, branch present, not running and fetch outstanding. This shows that each gate blocks issue by itself. Three slots qualify together under backpressure and a fourth joins later. The resulting issue order separates ascending-index, oldest-first ordering from any priority scheme, and shows that the held request stays steady. A flushed return followed by a normal one shows that the drop mark is used once and then cleared.

// File: rtl/wf_fetch_pkg.sv
package wf_fetch_pkg;
  // Instruction word size in bytes and the matching shift
  localparam int WORD_BYTES = 8;
  localparam int WORD_SHIFT = 3;
  // Highest buffer fill at which a slot may still refill
  localparam int OCC_LIMIT  = 4;
endpackage

// File: rtl/wf_fetch_elig.sv
module wf_fetch_elig #(
  parameter int N     = 8,
  parameter int OCC_W = 4
) (
  input  logic [N-1:0]       running,
  input  logic [N-1:0]       has_branch,
  input  logic [N*OCC_W-1:0] occ,
  input  logic [N-1:0]       pending,
  input  logic [N-1:0]       queued,
  output logic [N-1:0]       elig
);
  import wf_fetch_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic occ_ok;
    assign occ_ok  = (occ[g*OCC_W +: OCC_W] <= OCC_W'(OCC_LIMIT));
    assign elig[g] = running[g] & occ_ok & ~has_branch[g] & ~pending[g] & ~queued[g];
  end
endmodule

// File: rtl/wf_fetch_queue.sv
module wf_fetch_queue #(
  parameter int N      = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      push_vec,
  input  logic              pop,
  output logic              head_valid,
  output logic [SLOT_W-1:0] head_slot
);
  logic [SLOT_W-1:0] ent_q [N];
  logic [SLOT_W-1:0] ent_n [N];
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              ent_en;

  always_comb begin
    logic [SLOT_W-1:0] tmp [N];
    logic [CNT_W-1:0]  tcnt;
    tmp  = ent_q;
    tcnt = cnt_q;
    // Append this cycle's new slots in ascending index order
    for (int i = 0; i < N; i++) begin
      if (push_vec[i] && (tcnt < CNT_W'(N))) begin
        tmp[SLOT_W'(tcnt)] = SLOT_W'(i);
        tcnt = tcnt + CNT_W'(1);
      end
    end
    head_valid = (tcnt != '0);
    head_slot  = tmp[0];
    ent_n      = tmp;
    cnt_n      = tcnt;
    if (pop && (tcnt != '0)) begin
      for (int k = 0; k < N-1; k++) ent_n[k] = tmp[k+1];
      ent_n[N-1] = tmp[N-1];
      cnt_n      = tcnt - CNT_W'(1);
    end
  end

  assign ent_en = (|push_vec) | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (ent_en) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_n;
  end

  // R2
  q_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(N));
endmodule

// File: rtl/wf_fetch_addr.sv
module wf_fetch_addr #(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int OCC_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 7
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [PC_W-1:0]   pc,
  input  logic [OCC_W-1:0]  occ,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);
  import wf_fetch_pkg::*;
  localparam int LB_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] word_idx;
  logic [LB_W-1:0]   line_off;

  assign word_idx = ADDR_W'(pc) + ADDR_W'(occ);
  assign addr     = base + (word_idx << WORD_SHIFT);
  assign line_off = addr[LB_W-1:0];
  // Bytes left to the end of the line; a full line when aligned
  assign len      = LEN_W'(LINE_BYTES) - LEN_W'(line_off);
endmodule

// File: rtl/wf_fetch_ctrl.sv
module wf_fetch_ctrl #(
  parameter int N          = 8,
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int OCC_W      = 4,
  parameter int LINE_BYTES = 64,
  localparam int SLOT_W    = $clog2(N),
  localparam int CNT_W     = $clog2(N+1),
  localparam int LEN_W     = $clog2(LINE_BYTES) + 1,
  localparam int WCNT_W    = LEN_W - wf_fetch_pkg::WORD_SHIFT,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        slot_running,
  input  logic [N-1:0]        slot_has_branch,
  input  logic [N*OCC_W-1:0]  slot_occ,
  input  logic [N*PC_W-1:0]   slot_pc,
  input  logic [N*ADDR_W-1:0] slot_base,
  input  logic [N-1:0]        drop_set,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic [SLOT_W-1:0]   req_slot,
  input  logic                rsp_valid,
  input  logic [SLOT_W-1:0]   rsp_slot,
  input  logic [LEN_W-1:0]    rsp_len,
  input  logic [DATA_W-1:0]   rsp_data,
  output logic                ibuf_wr_valid,
  output logic [SLOT_W-1:0]   ibuf_wr_slot,
  output logic [WCNT_W-1:0]   ibuf_wr_count,
  output logic [DATA_W-1:0]   ibuf_wr_data
);
  import wf_fetch_pkg::*;

  logic [N-1:0]      pending_q, pending_n;
  logic [N-1:0]      queued_q,  queued_n;
  logic [N-1:0]      drop_q,    drop_n;
  logic [N-1:0]      elig;
  logic              head_valid;
  logic [SLOT_W-1:0] head_slot;
  logic              port_free, sel_fire;
  logic [N-1:0]      sel_hot, rsp_hot;
  logic [ADDR_W-1:0] sel_addr;
  logic [LEN_W-1:0]  sel_len;
  logic              req_valid_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [LEN_W-1:0]  req_len_q;
  logic [SLOT_W-1:0] req_slot_q;

  wf_fetch_elig #(.N(N), .OCC_W(OCC_W)) u_elig (
    .running    (slot_running),
    .has_branch (slot_has_branch),
    .occ        (slot_occ),
    .pending    (pending_q),
    .queued     (queued_q),
    .elig       (elig)
  );

  wf_fetch_queue #(.N(N), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_vec   (elig),
    .pop        (sel_fire),
    .head_valid (head_valid),
    .head_slot  (head_slot)
  );

  wf_fetch_addr #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .OCC_W(OCC_W),
    .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
  ) u_addr (
    .base (slot_base[head_slot*ADDR_W +: ADDR_W]),
    .pc   (slot_pc[head_slot*PC_W +: PC_W]),
    .occ  (slot_occ[head_slot*OCC_W +: OCC_W]),
    .addr (sel_addr),
    .len  (sel_len)
  );

  // Issue only when the port holds nothing or its content leaves now
  assign port_free = ~req_valid_q | req_ready;
  assign sel_fire  = head_valid & port_free;
  assign sel_hot   = sel_fire  ? (N'(1) << head_slot) : '0;
  assign rsp_hot   = rsp_valid ? (N'(1) << rsp_slot)  : '0;

  // Next-state for per-slot flags
  always_comb begin
    pending_n = (pending_q | sel_hot) & ~rsp_hot;
    queued_n  = (queued_q | elig) & ~sel_hot;
    drop_n    = drop_set | (drop_q & ~rsp_hot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      queued_q  <= '0;
      drop_q    <= '0;
    end else begin
      pending_q <= pending_n;
      queued_q  <= queued_n;
      drop_q    <= drop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_valid_q <= 1'b0;
    else if (port_free) req_valid_q <= sel_fire;
  end

  always_ff @(posedge clk) begin
    if (sel_fire) begin
      req_addr_q <= sel_addr;
      req_len_q  <= sel_len;
      req_slot_q <= head_slot;
    end
  end

  assign req_valid = req_valid_q;
  assign req_addr  = req_addr_q;
  assign req_len   = req_len_q;
  assign req_slot  = req_slot_q;

  assign ibuf_wr_valid = rsp_valid & ~drop_q[rsp_slot];
  assign ibuf_wr_slot  = rsp_slot;
  assign ibuf_wr_count = rsp_len[LEN_W-1:WORD_SHIFT];
  assign ibuf_wr_data  = rsp_data;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_q && !req_ready) |=>
      (req_valid_q && $stable(req_addr_q) && $stable(req_len_q) && $stable(req_slot_q)));

  // R11
  rsp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pending_q[rsp_slot]);

  // R11
  req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_q |-> pending_q[req_slot_q]);

  // R2
  queued_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (queued_q & pending_q) == '0);

  // R8
  drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && drop_q[rsp_slot]) |-> (slot_occ[rsp_slot*OCC_W +: OCC_W] == '0));
endmodule

// File: tb/test_wf_fetch_ctrl.sv
module test_wf_fetch_ctrl;
  localparam int N = 8, AW = 32, PW = 32, OW = 4, LB = 64;
  localparam int SW = 3, LW = 7, CW = 4, DW = 512;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] pc;
    logic [3:0]  occ;
    logic [31:0] addr;
    logic [6:0]  len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h1000, 32'h0,   4'd0, 32'h1000, 7'd64},
    '{32'h1000, 32'h1,   4'd0, 32'h1008, 7'd56},
    '{32'h1000, 32'h3,   4'd4, 32'h1038, 7'd8},
    '{32'h2040, 32'h2,   4'd2, 32'h2060, 7'd32},
    '{32'h3000, 32'h7,   4'd1, 32'h3040, 7'd64},
    '{32'h0FF8, 32'h0,   4'd0, 32'h0FF8, 7'd8},
    '{32'h4010, 32'h10,  4'd3, 32'h40A8, 7'd24},
    '{32'h5000, 32'h100, 4'd0, 32'h5800, 7'd64}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    run, br, drp;
  logic [N*OW-1:0] occ;
  logic [N*PW-1:0] pc;
  logic [N*AW-1:0] base;
  logic req_valid, req_ready, rsp_valid, ibuf_wr_valid;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len, rsp_len;
  logic [SW-1:0] req_slot, rsp_slot, ibuf_wr_slot;
  logic [CW-1:0] ibuf_wr_count;
  logic [DW-1:0] rsp_data, ibuf_wr_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wf_fetch_ctrl i_wf_fetch_ctrl (
    .clk(clk), .rst_n(rst_n),
    .slot_running(run), .slot_has_branch(br), .slot_occ(occ),
    .slot_pc(pc), .slot_base(base), .drop_set(drp),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_slot(req_slot),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_len(rsp_len), .rsp_data(rsp_data),
    .ibuf_wr_valid(ibuf_wr_valid), .ibuf_wr_slot(ibuf_wr_slot),
    .ibuf_wr_count(ibuf_wr_count), .ibuf_wr_data(ibuf_wr_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_slot(input int s, input logic [31:0] b, input logic [31:0] p, input logic [3:0] o);
    base[s*AW +: AW] = b;
    pc[s*PW +: PW]   = p;
    occ[s*OW +: OW]  = o;
  endtask

  task automatic check_req(input string tag, input int s, input logic [31:0] a, input logic [6:0] l);
    chk({tag, " valid"}, 64'(req_valid), 64'd1);
    chk({tag, " slot"},  64'(req_slot),  64'(s));
    chk({tag, " addr"},  64'(req_addr),  64'(a));
    chk({tag, " len"},   64'(req_len),   64'(l));
  endtask

  // Called at a negedge; leaves at the negedge after the return edge
  task automatic respond(input int s, input logic [6:0] l, input logic wr_exp);
    rsp_valid = 1'b1;
    rsp_slot  = SW'(s);
    rsp_len   = l;
    for (int i = 0; i < 8; i++) rsp_data[i*64 +: 64] = {32'hC0DE0000 | 32'(s), 32'(i)};
    #1;
    chk("R8/R9 write valid", 64'(ibuf_wr_valid), 64'(wr_exp));
    if (wr_exp) begin
      chk("R9 write slot",  64'(ibuf_wr_slot),  64'(s));
      chk("R9 word count",  64'(ibuf_wr_count), 64'(l >> 3));
      chk("R9 first word",  ibuf_wr_data[63:0], {32'hC0DE0000 | 32'(s), 32'd0});
    end
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = '0; br = '0; drp = '0; occ = '0; pc = '0; base = '0;
    req_ready = 1'b1; rsp_valid = 1'b0; rsp_slot = '0; rsp_len = '0; rsp_data = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 req_valid in reset", 64'(req_valid), 64'd0);
    chk("R10 write idle in reset", 64'(ibuf_wr_valid), 64'd0);
    rst_n = 1'b1;
    tick();
    chk("R10 req_valid after reset", 64'(req_valid), 64'd0);

    // Table walk: R4 issue timing, R5 address, R6 length, R9 return
    for (int v = 0; v < 8; v++) begin
      set_slot(v, VECS[v].base, VECS[v].pc, VECS[v].occ);
      run[v] = 1'b1;
      tick();
      check_req("R4/R5/R6 table", v, VECS[v].addr, VECS[v].len);
      run[v] = 1'b0;
      tick();
      chk("R4 port idle after accept", 64'(req_valid), 64'd0);
      respond(v, VECS[v].len, 1'b1);
      set_slot(v, 32'h0, 32'h0, 4'd0);
      tick();
    end

    // R1: each gate blocks on its own
    set_slot(1, 32'h100, 32'h0, 4'd5);
    run[1] = 1'b1;
    tick(); tick();
    chk("R1 occupancy 5 blocks", 64'(req_valid), 64'd0);
    occ[1*OW +: OW] = 4'd4; br[1] = 1'b1;
    tick(); tick();
    chk("R1 branch blocks", 64'(req_valid), 64'd0);
    br[1] = 1'b0; run[1] = 1'b0;
    tick(); tick();
    chk("R1 not running blocks", 64'(req_valid), 64'd0);
    run[1] = 1'b1;
    tick();
    check_req("R1 occupancy 4 issues", 1, 32'h120, 7'd32);
    tick(); tick(); tick();
    // R11: still running but outstanding, no second request
    chk("R11 no reissue while outstanding", 64'(req_valid), 64'd0);
    respond(1, 7'd32, 1'b1);
    tick();
    check_req("R9 outstanding cleared, reissue", 1, 32'h120, 7'd32);
    run[1] = 1'b0;
    tick();
    respond(1, 7'd32, 1'b1);
    set_slot(1, 32'h0, 32'h0, 4'd0);
    tick();

    // R3/R7/R2: ordering under backpressure
    req_ready = 1'b0;
    for (int s = 0; s < 8; s++) set_slot(s, 32'h6000 + 32'(s) * 32'h100, 32'h0, 4'd0);
    run[5] = 1'b1; run[2] = 1'b1; run[6] = 1'b1;
    tick();
    check_req("R3 lowest index first", 2, 32'h6200, 7'd64);
    run[1] = 1'b1;
    tick();
    check_req("R7 held while not ready", 2, 32'h6200, 7'd64);
    tick();
    check_req("R7 still held", 2, 32'h6200, 7'd64);
    req_ready = 1'b1;
    tick();
    check_req("R3 second oldest", 5, 32'h6500, 7'd64);
    tick();
    check_req("R3 third oldest", 6, 32'h6600, 7'd64);
    tick();
    check_req("R3 late arrival last", 1, 32'h6100, 7'd64);
    tick();
    chk("R2 each slot issued once", 64'(req_valid), 64'd0);
    run = '0;
    respond(2, 7'd64, 1'b1);
    respond(5, 7'd64, 1'b1);
    respond(6, 7'd64, 1'b1);
    respond(1, 7'd64, 1'b1);
    for (int s = 0; s < 8; s++) set_slot(s, 32'h0, 32'h0, 4'd0);
    tick();

    // R8: stale return dropped once, then normal
    set_slot(3, 32'h7000, 32'h0, 4'd0);
    run[3] = 1'b1;
    tick();
    check_req("R8 first fetch", 3, 32'h7000, 7'd64);
    run[3] = 1'b0;
    drp[3] = 1'b1;
    tick();
    drp[3] = 1'b0;
    respond(3, 7'd64, 1'b0);
    run[3] = 1'b1;
    tick();
    check_req("R8 refetch after drop", 3, 32'h7000, 7'd64);
    run[3] = 1'b0;
    tick();
    respond(3, 7'd64, 1'b1);
    tick();
    chk("R10 port idle at end", 64'(req_valid), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule